// File: doc/BRIEF.md
# Bitmapped Monochrome VGA Controller with DMA Fetch

This block turns a 12 MHz system clock into VGA-compatible raster timing and paints a 576 x 455 one-bit-per-pixel picture held in system RAM. A horizontal counter of 9 bits walks the 381 clocks of each line. A vertical counter of 10 bits walks the 528 lines of each frame. Together they decide when video is visible and when the active-low sync pulses are driven.

Picture data arrives as 16-bit words through a request/acknowledge DMA handshake. On every eighth clock of a visible line the block raises a request. The memory side answers within five clocks by pulsing the acknowledge with the word on the data input. The word waits in a staging register and moves into a shift register on the last clock of its eight-clock group. From there two pixels leave per clock, one while the clock is high and one while it is low. The pixel bit drives all six colour outputs, so the picture is black or white. On the last clock of each frame a one-clock pulse tells the DMA engine to rewind its address counter.

All line and frame counts are parameters. The defaults give the timing described here.

Top module: `bitmap_vga_dma`

## Requirements
- R1: While `rst_n` is low at a clock edge, both syncs are high, every colour output is 00, `dma_req` and `dma_addr_rst` are low, and after release the counters restart at clock 0 of line 0.
- R2: A line lasts 381 clocks (clock 0 to 380). `hsync_n` is low exactly on clocks 308 through 352 and high otherwise.
- R3: A frame lasts `V_TOTAL` lines (528 by default). The line number advances after clock 380. `vsync_n` is low exactly on lines `V_SYNC_ON` to `V_SYNC_OFF`-1 (486 and 487 by default).
- R4: `dma_addr_rst` is high for exactly one clock per frame: clock 380 of the last line.
- R5: On a line below `V_VISIBLE` (455), each clock whose number is a multiple of 8 and below 288 issues a fetch, and `dma_req` rises in the following clock. That makes 36 fetches per line, and no request rises at any other time.
- R6: Once raised, `dma_req` stays high until `dma_ack` is high at a clock edge. It is low in the clock after that edge.
- R7: `dma_ack` at an edge where `dma_req` is high captures `pix_word`. `dma_ack` while `dma_req` is low has no effect on the picture.
- R8: The word fetched at clock 8g is shown during clocks 8g+8 to 8g+15, bit 15 first. Within each clock the high phase shows the even bit (15, 13, ...) and the low phase shows the next lower bit. Any acknowledge latency from 1 to 5 clocks gives the same picture.
- R9: The three colour outputs are always equal. Each is {pix, pix}: 11 for a set bit and 00 for a clear bit.
- R10: Outside the display window (clocks other than 8 to 295, or lines at or after `V_VISIBLE`) every colour output is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both phases carry a pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_word | input | 16 | Pixel word delivered with the acknowledge |
| dma_ack | input | 1 | Acknowledge: `pix_word` is valid this clock |
| dma_req | output | 1 | Pending request for the next pixel word |
| dma_addr_rst | output | 1 | One-clock pulse at frame end to rewind the DMA address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
The hardest case to reach is an acknowledge that arrives while no request is pending. It must land between a real acknowledge and the load into the shift register, because only there could a wrong capture change the picture. The bench's DMA responder injects such stray acknowledges with inverted data on clock 6 of every group. It also runs whole frames at both latency extremes of 1 and 5 clocks, and it checks every half-clock pixel against a model built from the word sequence it served. Since a full default frame is longer than the run budget, the bench shortens only the vertical counts. It keeps the default line timing, so line and frame wrap, vertical sync and the address rewind are all reached several times, including after a reset applied in the middle of a frame.

// File: rtl/vga_dma_pkg.sv
// Package: shared constants for the bitmapped VGA controller.
// Assumes one-bit pixels and two pixels per clock (one per clock phase).
package vga_dma_pkg;
    localparam int PIX_PER_CLK = 2;
    localparam int COLOR_W     = 2;
    localparam int N_CHANNELS  = 3;
endpackage

// File: rtl/vga_span_counter.sv
// Module: wrapping raster counter with visible window and sync window decode.
// Assumes VISIBLE <= SYNC_ON < SYNC_OFF <= TOTAL and TOTAL fits in CNT_W bits.
// The count advances only when step is high and wraps after TOTAL-1.
module vga_span_counter #(
    parameter int CNT_W    = 9,
    parameter int TOTAL    = 381,
    parameter int VISIBLE  = 288,
    parameter int SYNC_ON  = 308,
    parameter int SYNC_OFF = 353
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             visible,
    output logic             sync_n,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] VIS_END  = CNT_W'(VISIBLE);
    localparam logic [CNT_W-1:0] SYN_ON   = CNT_W'(SYNC_ON);
    localparam logic [CNT_W-1:0] SYN_OFF  = CNT_W'(SYNC_OFF);

    // Position register: clears on reset, wraps at the end of the span.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (step)
            count <= last ? '0 : count + 1'b1;
    end

    // Window decode from the registered position.
    always_comb begin
        last    = (count == LAST_VAL);
        visible = (count < VIS_END);
        sync_n  = !((count >= SYN_ON) && (count < SYN_OFF));
    end
endmodule

// File: rtl/vga_pixel_fetch.sv
// Module: DMA fetch pacing, word staging and double-rate pixel shifting.
// Assumes the acknowledge arrives within GROUP_CLKS-3 clocks of the request,
// so that a staged word is always ready at the load clock of its group.
// The picture therefore trails the raster counters by one group of clocks.
module vga_pixel_fetch #(
    parameter int WORD_W     = 16,
    parameter int GROUP_CLKS = 8,
    parameter int GRP_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              window,
    input  logic [GRP_W-1:0]  phase,
    input  logic              dma_ack,
    input  logic [WORD_W-1:0] pix_word,
    output logic              dma_req,
    output logic              pix
);
    localparam logic [GRP_W-1:0] LOAD_PHASE = GRP_W'(GROUP_CLKS - 1);

    logic              strobe;
    logic              load;
    logic              pending;
    logic              show;
    logic [WORD_W-1:0] stage;
    logic [WORD_W-1:0] shreg;

    // Group timing: fetch on the first clock, load on the last.
    always_comb begin
        strobe = window && (phase == '0);
        load   = (phase == LOAD_PHASE);
    end

    // Pending request: set by the strobe, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (strobe)
            pending <= 1'b1;
        else if (dma_ack)
            pending <= 1'b0;
    end

    // Staging register: captures the word only for a pending request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= '0;
        else if (dma_ack && pending)
            stage <= pix_word;
    end

    // Shift register: loads the staged word, else moves two bits per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            show  <= 1'b0;
        end else if (load) begin
            shreg <= stage;
            show  <= window;
        end else begin
            shreg <= {shreg[WORD_W-3:0], 2'b00};
        end
    end

    // Half-clock pixel select: high phase takes the upper bit of the pair.
    always_comb begin
        dma_req = pending;
        pix     = show & (clk ? shreg[WORD_W-1] : shreg[WORD_W-2]);
    end
endmodule

// File: rtl/bitmap_vga_dma.sv
// Module: top of the bitmapped monochrome VGA controller.
// Assumes a 12 MHz clock, a DMA agent that answers within five clocks,
// and one bit per pixel replicated onto every colour output.
module bitmap_vga_dma #(
    parameter int WORD_W     = 16,
    parameter int H_W        = 9,
    parameter int H_TOTAL    = 381,
    parameter int H_VISIBLE  = 288,
    parameter int H_SYNC_ON  = 308,
    parameter int H_SYNC_OFF = 353,
    parameter int V_W        = 10,
    parameter int V_TOTAL    = 528,
    parameter int V_VISIBLE  = 455,
    parameter int V_SYNC_ON  = 486,
    parameter int V_SYNC_OFF = 488
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pix_word,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic              dma_addr_rst,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic [1:0]        red,
    output logic [1:0]        green,
    output logic [1:0]        blue
);
    import vga_dma_pkg::*;

    localparam int GROUP_CLKS = WORD_W / PIX_PER_CLK;
    localparam int GRP_W      = $clog2(GROUP_CLKS);

    logic [H_W-1:0] h_count;
    logic [V_W-1:0] v_count;
    logic           h_vis, v_vis, h_last, v_last;
    logic           pix;
    logic [COLOR_W-1:0] chan [N_CHANNELS];

    vga_span_counter #(
        .CNT_W(H_W), .TOTAL(H_TOTAL), .VISIBLE(H_VISIBLE),
        .SYNC_ON(H_SYNC_ON), .SYNC_OFF(H_SYNC_OFF)
    ) i_hcount (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .count(h_count), .visible(h_vis), .sync_n(hsync_n), .last(h_last)
    );

    vga_span_counter #(
        .CNT_W(V_W), .TOTAL(V_TOTAL), .VISIBLE(V_VISIBLE),
        .SYNC_ON(V_SYNC_ON), .SYNC_OFF(V_SYNC_OFF)
    ) i_vcount (
        .clk(clk), .rst_n(rst_n), .step(h_last),
        .count(v_count), .visible(v_vis), .sync_n(vsync_n), .last(v_last)
    );

    vga_pixel_fetch #(
        .WORD_W(WORD_W), .GROUP_CLKS(GROUP_CLKS), .GRP_W(GRP_W)
    ) i_fetch (
        .clk(clk), .rst_n(rst_n),
        .window(h_vis && v_vis),
        .phase(h_count[GRP_W-1:0]),
        .dma_ack(dma_ack), .pix_word(pix_word),
        .dma_req(dma_req), .pix(pix)
    );

    // Colour fan-out: each channel carries the same pixel on every bit.
    for (genvar c = 0; c < N_CHANNELS; c++) begin : g_chan
        assign chan[c] = {COLOR_W{pix}};
    end

    // Output mapping and end-of-frame address rewind pulse.
    always_comb begin
        red          = chan[0];
        green        = chan[1];
        blue         = chan[2];
        dma_addr_rst = h_last && v_last;
    end
endmodule

// File: rtl/vga_dma_chk.sv
// Module: protocol and timing checker bound into the VGA controller top.
// Assumes the DMA agent never acknowledges later than five clocks.
module vga_dma_chk #(
    parameter int H_W       = 9,
    parameter int V_W       = 10,
    parameter int H_VISIBLE = 288,
    parameter int V_VISIBLE = 455
) (
    input logic           clk,
    input logic           rst_n,
    input logic [H_W-1:0] h_count,
    input logic [V_W-1:0] v_count,
    input logic           dma_req,
    input logic           dma_ack,
    input logic           dma_addr_rst,
    input logic           hsync_n,
    input logic           vsync_n,
    input logic [1:0]     red,
    input logic [1:0]     green,
    input logic [1:0]     blue
);
    p_hsync_in_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> (h_count >= H_VISIBLE));

    p_vsync_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> (v_count >= V_VISIBLE));

    p_rewind_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_addr_rst |=> (!dma_addr_rst && h_count == '0 && v_count == '0));

    p_req_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> ($past(h_count[2:0]) == 3'd0 &&
                            $past(h_count) < H_VISIBLE &&
                            $past(v_count) < V_VISIBLE));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    p_req_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    p_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (red == green) && (green == blue));

    p_dark_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_count >= V_VISIBLE) |-> (red == 2'b00));
endmodule

bind bitmap_vga_dma vga_dma_chk #(
    .H_W(H_W), .V_W(V_W), .H_VISIBLE(H_VISIBLE), .V_VISIBLE(V_VISIBLE)
) i_vga_dma_chk (
    .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_addr_rst(dma_addr_rst),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue)
);

// File: tb/test_bitmap_vga_dma.sv
// Bench: directed scenarios for the bitmapped VGA controller.
// The vertical counts are shortened so whole frames fit the run budget.
module test_bitmap_vga_dma;
    localparam int HT = 381, HV = 288, HS0 = 308, HS1 = 353;
    localparam int VT = 10, VV = 4, VS0 = 6, VS1 = 8;
    localparam int WPL = HV / 8;
    localparam int FRAME = HT * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_word = '0;
    logic        dma_ack = 1'b0;
    logic        dma_req, dma_addr_rst, hsync_n, vsync_n;
    logic [1:0]  red, green, blue;

    int compared = 0, mismatched = 0, cyc = 0;
    int ack_delay = 3, word_i = 0, wait_cnt = 0;
    bit stray_en = 1'b0, done = 1'b0;

    bitmap_vga_dma #(
        .V_TOTAL(VT), .V_VISIBLE(VV), .V_SYNC_ON(VS0), .V_SYNC_OFF(VS1)
    ) i_bitmap_vga_dma (
        .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .dma_ack(dma_ack),
        .dma_req(dma_req), .dma_addr_rst(dma_addr_rst),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .red(red), .green(green), .blue(blue)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [15:0] wordval(int i);
        return 16'((i * 40503 + 4660) ^ (i << 5));
    endfunction

    // DMA responder: answers after ack_delay clocks, optional stray acks.
    initial forever begin
        @(negedge clk);
        dma_ack = 1'b0;
        if (!rst_n) begin
            word_i = 0; wait_cnt = 0;
        end else if (dma_req) begin
            wait_cnt++;
            if (wait_cnt >= ack_delay) begin
                dma_ack  = 1'b1;
                pix_word = wordval(word_i % (WPL * VV));
                word_i++;
                wait_cnt = 0;
            end
        end else begin
            wait_cnt = 0;
            if (stray_en && (cyc % HT) % 8 == 6 && (cyc % HT) < HV) begin
                dma_ack  = 1'b1;
                pix_word = ~wordval(word_i % (WPL * VV));
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic goto(int k);
        while (cyc < k) begin @(posedge clk); #1; end
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Scenario: reset forces idle outputs (R1).
    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk("R1 hsync", hsync_n, 1); chk("R1 vsync", vsync_n, 1);
        chk("R1 req", dma_req, 0);   chk("R1 rewind", dma_addr_rst, 0);
        chk("R1 colour high", {red, green, blue}, 0);
        #4;
        chk("R1 colour low", {red, green, blue}, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Scenario: one full frame at a given ack latency, every half clock checked.
    task automatic t_frame(int f, int delay, bit stray);
        bit prev_req = 1'b0, prev_ack = 1'b0;
        ack_delay = delay; stray_en = stray;
        for (int k = (f == 0 ? 1 : f * FRAME); k < (f + 1) * FRAME; k++) begin
            int h = k % HT;
            int v = (k / HT) % VT;
            bit show = (v < VV) && (h >= 8) && (h < HV + 8);
            logic b_hi = 1'b0, b_lo = 1'b0;
            string tag = show ? (stray ? "R7 stray ack" : "R8 pixel") : "R10 blank";
            if (show) begin
                logic [15:0] w = wordval(v * WPL + (h - 8) / 8);
                int p = (h - 8) % 8;
                b_hi = w[15 - 2 * p]; b_lo = w[14 - 2 * p];
            end
            goto(k);
            chk("R2 hsync", hsync_n, !(h >= HS0 && h < HS1));
            chk("R3 vsync", vsync_n, !(v >= VS0 && v < VS1));
            chk("R4 rewind", dma_addr_rst, (h == HT - 1 && v == VT - 1));
            chk("R5 req rise", (!prev_req && dma_req),
                (h >= 1 && (h - 1) % 8 == 0 && (h - 1) < HV && v < VV));
            if (prev_req) chk("R6 req hold/clear", dma_req, !prev_ack);
            chk(tag, red, {b_hi, b_hi});
            chk("R9 mono", {green, blue}, {red, red});
            #4;
            chk(tag, red, {b_lo, b_lo});
            chk("R9 mono", {green, blue}, {red, red});
            prev_req = dma_req;
            prev_ack = dma_ack;
        end
    endtask

    initial begin
        #(8 * 200000);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_frame(0, 3, 1'b0);
        t_frame(1, 1, 1'b0);
        t_frame(2, 5, 1'b1);
        goto(3 * FRAME + 500);
        t_reset();
        t_frame(0, 2, 1'b1);
        finish_run();
    end
endmodule